// File: doc/BRIEF.md
# Configuration change protection unit

This unit gates two kinds of sensitive operation in a processor subsystem: writes to protected configuration registers, and execution of the protected program-memory store/load instruction. Software opens a gate by having the CPU write a key byte into the unlock register on the register bus. A matching key opens a short window whose length is counted in retired CPU instructions, not in clock cycles. While the window is open, the matching enable output is high, and interrupt service is held off.

The window closes on its own after four retired instructions. It also closes early when the guarded operation takes place or when the program-memory window is aborted. A key written by the DMA master is ignored. Interrupt requests that arrive during the window are latched as pending and handed to the interrupt controller once the window has closed. The unlock register reads back the active mode in its two low bits.

The window logic is a three-state machine. The states are WS_IDLE, WS_IO_OPEN and WS_PGM_OPEN. The transitions are: T_KEY_IO (valid I/O key, from any state, to WS_IO_OPEN), T_KEY_PGM (valid program-memory key, from any state, to WS_PGM_OPEN), T_EXPIRE (fourth retire in either open state, to WS_IDLE), T_CONSUME (protected register write in WS_IO_OPEN, to WS_IDLE) and T_ABORT (data-memory write or sleep in WS_PGM_OPEN, to WS_IDLE). A key beats every other event in the same cycle. Next come T_CONSUME and T_ABORT, and T_EXPIRE comes last.

Top module: `cfgprot_unit`

## Requirements
- R1: A CPU write (bus_wr=1, bus_sel=1, bus_is_dma=0) of 0xD8 opens the I/O window from the next clock edge: io_unlock=1 and pgm_unlock=0.
- R2: A CPU write of 0x9D opens the program-memory window from the next clock edge: pgm_unlock=1 and io_unlock=0.
- R3: An open window closes at the clock edge that samples the fourth instr_retire=1 cycle after it opened. A retire in the key-write cycle does not count, and cycles without instr_retire do not count.
- R4: A key written with bus_is_dma=1 changes nothing: no window opens, and an open window is neither restarted nor closed.
- R5: A CPU write of any value other than the two keys, and any write with bus_sel=0, leaves the window state and its instruction count unchanged.
- R6: A valid CPU key written while a window is open switches to the mode of the new key and restarts the count. io_unlock and pgm_unlock are never both 1.
- R7: In the program-memory window, dmem_wr=1 or sleep_exec=1 closes the window at the next edge. In the I/O window, neither signal has any effect.
- R8: In the I/O window, prot_reg_wr=1 closes the window at the next edge. In the program-memory window, prot_reg_wr has no effect.
- R9: irq_hold is 1 exactly while a window is open, and irq_take is then all zero.
- R10: irq_req[i]=1 sets irq_pend[i] at the next edge. The bit stays set until irq_ack[i]=1 in a cycle with no window open. If request and acknowledge arrive in the same cycle, the request wins. irq_take equals irq_pend whenever no window is open.
- R11: bus_rdata bit 0 equals io_unlock, bit 1 equals pgm_unlock, and bits 7:2 read 0.
- R12: After reset, no window is open, bus_rdata is 0x00 and irq_pend is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register-bus write strobe |
| bus_sel | input | 1 | Unlock register addressed |
| bus_is_dma | input | 1 | Current bus master is DMA (1) or CPU (0) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Unlock register read-back |
| instr_retire | input | 1 | One CPU instruction retired this cycle |
| dmem_wr | input | 1 | CPU data-memory write this cycle |
| sleep_exec | input | 1 | CPU executes sleep this cycle |
| prot_reg_wr | input | 1 | Write to a protected configuration register this cycle |
| irq_req | input | IRQ_N | Interrupt request pulses |
| irq_ack | input | IRQ_N | Interrupt controller accepted a line |
| irq_pend | output | IRQ_N | Latched pending requests |
| irq_take | output | IRQ_N | Pending requests released for service |
| irq_hold | output | 1 | Interrupt service suppressed |
| io_unlock | output | 1 | Protected I/O register change enabled |
| pgm_unlock | output | 1 | Protected program-memory instruction enabled |

## Verification
The bench uses the default parameters: an 8-bit bus, keys 0xD8 and 0x9D, a four-instruction window and four interrupt lines. With a window that short, random traffic often reaches natural expiry, and often mixes expiry with restarts, aborts and consumption in the same few cycles. Four request lines are enough to show requests colliding with acknowledges while a window is open and while none is.

// File: rtl/cfgprot_pkg.sv
package cfgprot_pkg;

    typedef enum logic [1:0] {
        WS_IDLE     = 2'd0,
        WS_IO_OPEN  = 2'd1,
        WS_PGM_OPEN = 2'd2
    } win_state_t;

    typedef struct packed {
        logic key_io;
        logic key_pgm;
    } key_req_t;

endpackage

// File: rtl/cfgprot_keydec.sv
module cfgprot_keydec
    import cfgprot_pkg::*;
#(
    parameter int          DATA_W  = 8,
    parameter logic [7:0]  KEY_IO  = 8'hD8,
    parameter logic [7:0]  KEY_PGM = 8'h9D
) (
    input  logic              bus_wr,
    input  logic              bus_sel,
    input  logic              bus_is_dma,
    input  logic [DATA_W-1:0] bus_wdata,
    output key_req_t          key
);
    // Only CPU-originated writes to the unlock register may carry a key.
    logic cpu_write;

    assign cpu_write = bus_wr && bus_sel && !bus_is_dma;

    always_comb begin
        key.key_io  = cpu_write && (bus_wdata == DATA_W'(KEY_IO));
        key.key_pgm = cpu_write && (bus_wdata == DATA_W'(KEY_PGM));
    end

endmodule

// File: rtl/cfgprot_wincnt.sv
module cfgprot_wincnt #(
    parameter int WIN_INSTR = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic open,
    input  logic retire,
    output logic expire
);
    localparam int            CW   = $clog2(WIN_INSTR + 1);
    localparam logic [CW-1:0] LAST = CW'(WIN_INSTR - 1);

    logic [CW-1:0] cnt;

    // Counts retired instructions inside the window; one per strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (open && retire) begin
            cnt <= cnt + 1'b1;
        end else if (!open) begin
            cnt <= '0;
        end
    end

    assign expire = open && retire && (cnt == LAST);

endmodule

// File: rtl/cfgprot_irqhold.sv
module cfgprot_irqhold #(
    parameter int IRQ_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [IRQ_N-1:0] irq_req,
    input  logic [IRQ_N-1:0] irq_ack,
    output logic [IRQ_N-1:0] irq_pend,
    output logic [IRQ_N-1:0] irq_take
);
    for (genvar g = 0; g < IRQ_N; g++) begin : g_line
        logic flag;

        // A new request wins over an acknowledge in the same cycle;
        // acknowledges are not honoured while service is held.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag <= 1'b0;
            end else if (irq_req[g]) begin
                flag <= 1'b1;
            end else if (irq_ack[g] && !hold) begin
                flag <= 1'b0;
            end
        end

        assign irq_pend[g] = flag;
        assign irq_take[g] = flag && !hold;
    end

endmodule

// File: rtl/cfgprot_unit.sv
module cfgprot_unit
    import cfgprot_pkg::*;
#(
    parameter int         DATA_W    = 8,
    parameter int         WIN_INSTR = 4,
    parameter int         IRQ_N     = 4,
    parameter logic [7:0] KEY_IO    = 8'hD8,
    parameter logic [7:0] KEY_PGM   = 8'h9D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_sel,
    input  logic              bus_is_dma,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              instr_retire,
    input  logic              dmem_wr,
    input  logic              sleep_exec,
    input  logic              prot_reg_wr,
    input  logic [IRQ_N-1:0]  irq_req,
    input  logic [IRQ_N-1:0]  irq_ack,
    output logic [IRQ_N-1:0]  irq_pend,
    output logic [IRQ_N-1:0]  irq_take,
    output logic              irq_hold,
    output logic              io_unlock,
    output logic              pgm_unlock
);
    localparam int PAD_W = DATA_W - 2;

    win_state_t state_q, state_d;
    key_req_t   key;
    logic       win_open;
    logic       expire;
    logic       restart;

    cfgprot_keydec #(
        .DATA_W  (DATA_W),
        .KEY_IO  (KEY_IO),
        .KEY_PGM (KEY_PGM)
    ) u_keydec (
        .bus_wr     (bus_wr),
        .bus_sel    (bus_sel),
        .bus_is_dma (bus_is_dma),
        .bus_wdata  (bus_wdata),
        .key        (key)
    );

    assign restart = key.key_io || key.key_pgm;

    cfgprot_wincnt #(
        .WIN_INSTR (WIN_INSTR)
    ) u_wincnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .open    (win_open),
        .retire  (instr_retire),
        .expire  (expire)
    );

    // Next-state logic. Priority: key, then consume/abort, then expiry.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE: begin
                if (key.key_io)       state_d = WS_IO_OPEN;   // T_KEY_IO
                else if (key.key_pgm) state_d = WS_PGM_OPEN;  // T_KEY_PGM
            end
            WS_IO_OPEN: begin
                if (key.key_io)       state_d = WS_IO_OPEN;   // T_KEY_IO restart
                else if (key.key_pgm) state_d = WS_PGM_OPEN;  // T_KEY_PGM
                else if (prot_reg_wr) state_d = WS_IDLE;      // T_CONSUME
                else if (expire)      state_d = WS_IDLE;      // T_EXPIRE
            end
            WS_PGM_OPEN: begin
                if (key.key_io)                  state_d = WS_IO_OPEN;   // T_KEY_IO
                else if (key.key_pgm)            state_d = WS_PGM_OPEN;  // T_KEY_PGM restart
                else if (dmem_wr || sleep_exec)  state_d = WS_IDLE;      // T_ABORT
                else if (expire)                 state_d = WS_IDLE;      // T_EXPIRE
            end
            default: state_d = WS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the current state.
    always_comb begin
        io_unlock  = 1'b0;
        pgm_unlock = 1'b0;
        unique case (state_q)
            WS_IDLE:     ;
            WS_IO_OPEN:  io_unlock  = 1'b1;
            WS_PGM_OPEN: pgm_unlock = 1'b1;
            default:     ;
        endcase
        win_open  = io_unlock || pgm_unlock;
        irq_hold  = win_open;
        bus_rdata = {{PAD_W{1'b0}}, pgm_unlock, io_unlock};
    end

    cfgprot_irqhold #(
        .IRQ_N (IRQ_N)
    ) u_irqhold (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (irq_hold),
        .irq_req  (irq_req),
        .irq_ack  (irq_ack),
        .irq_pend (irq_pend),
        .irq_take (irq_take)
    );

endmodule

// File: rtl/cfgprot_unit_chk.sv
module cfgprot_unit_chk #(
    parameter int         DATA_W    = 8,
    parameter int         WIN_INSTR = 4,
    parameter int         IRQ_N     = 4,
    parameter logic [7:0] KEY_IO    = 8'hD8,
    parameter logic [7:0] KEY_PGM   = 8'h9D
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_sel,
    input logic              bus_is_dma,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              instr_retire,
    input logic              dmem_wr,
    input logic              sleep_exec,
    input logic              prot_reg_wr,
    input logic [IRQ_N-1:0]  irq_req,
    input logic [IRQ_N-1:0]  irq_take,
    input logic [IRQ_N-1:0]  irq_pend,
    input logic              irq_hold,
    input logic              io_unlock,
    input logic              pgm_unlock
);
    localparam int CKW = $clog2(WIN_INSTR + 2);

    logic           cpu_wr, cpu_io, cpu_pgm, cpu_key, any_open;
    logic [CKW-1:0] ck_cnt;

    assign cpu_wr   = bus_wr && bus_sel && !bus_is_dma;
    assign cpu_io   = cpu_wr && (bus_wdata == DATA_W'(KEY_IO));
    assign cpu_pgm  = cpu_wr && (bus_wdata == DATA_W'(KEY_PGM));
    assign cpu_key  = cpu_io || cpu_pgm;
    assign any_open = io_unlock || pgm_unlock;

    // Independent count of retires seen inside the current window.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      ck_cnt <= '0;
        else if (cpu_key)                ck_cnt <= '0;
        else if (any_open && instr_retire) ck_cnt <= ck_cnt + 1'b1;
        else if (!any_open)              ck_cnt <= '0;
    end

    p_io_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_io |=> (io_unlock && !pgm_unlock));

    p_pgm_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_pgm |=> (pgm_unlock && !io_unlock));

    p_window_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        any_open |-> (ck_cnt < CKW'(WIN_INSTR)));

    p_dma_key_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_open && bus_wr && bus_sel && bus_is_dma) |=> !any_open);

    p_bad_key_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_unlock && bus_wr && !cpu_key && !instr_retire && !prot_reg_wr) |=> io_unlock);

    p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_unlock, pgm_unlock}));

    p_pgm_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_unlock && (dmem_wr || sleep_exec) && !cpu_key) |=> !pgm_unlock);

    p_io_consume_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_unlock && prot_reg_wr && !cpu_key) |=> !io_unlock);

    p_hold_masks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        any_open |-> (irq_hold && (irq_take == '0)));

    p_req_latched_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req != '0) |=> ((irq_pend & $past(irq_req)) == $past(irq_req)));

endmodule

bind cfgprot_unit cfgprot_unit_chk #(
    .DATA_W    (DATA_W),
    .WIN_INSTR (WIN_INSTR),
    .IRQ_N     (IRQ_N),
    .KEY_IO    (KEY_IO),
    .KEY_PGM   (KEY_PGM)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_sel      (bus_sel),
    .bus_is_dma   (bus_is_dma),
    .bus_wdata    (bus_wdata),
    .instr_retire (instr_retire),
    .dmem_wr      (dmem_wr),
    .sleep_exec   (sleep_exec),
    .prot_reg_wr  (prot_reg_wr),
    .irq_req      (irq_req),
    .irq_take     (irq_take),
    .irq_pend     (irq_pend),
    .irq_hold     (irq_hold),
    .io_unlock    (io_unlock),
    .pgm_unlock   (pgm_unlock)
);

// File: tb/sim_cfgprot_unit.sv
`timescale 1ns/1ps
module sim_cfgprot_unit;

    localparam int DW = 8;
    localparam int NI = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 0, bus_sel = 0, bus_is_dma = 0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          instr_retire = 0, dmem_wr = 0, sleep_exec = 0, prot_reg_wr = 0;
    logic [NI-1:0] irq_req = '0, irq_ack = '0;
    logic [NI-1:0] irq_pend, irq_take;
    logic          irq_hold, io_unlock, pgm_unlock;

    always #5 clk = ~clk;

    cfgprot_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_is_dma(bus_is_dma), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .instr_retire(instr_retire), .dmem_wr(dmem_wr), .sleep_exec(sleep_exec),
        .prot_reg_wr(prot_reg_wr), .irq_req(irq_req), .irq_ack(irq_ack),
        .irq_pend(irq_pend), .irq_take(irq_take), .irq_hold(irq_hold),
        .io_unlock(io_unlock), .pgm_unlock(pgm_unlock)
    );

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    string       cur_tag = "R12";

    // Reference model state: 0 idle, 1 I/O window, 2 program-memory window.
    int            m_mode = 0;
    int            m_cnt  = 0;
    logic [NI-1:0] m_pend = '0;

    function automatic logic [DW-1:0] exp_rdata();
        return {6'b0, (m_mode == 2), (m_mode == 1)};
    endfunction

    function automatic logic [NI-1:0] exp_take();
        return (m_mode != 0) ? '0 : m_pend;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(cur_tag, "io_unlock",  32'(io_unlock),  32'(m_mode == 1));
        chk(cur_tag, "pgm_unlock", 32'(pgm_unlock), 32'(m_mode == 2));
        chk("R9",  "irq_hold",  32'(irq_hold),  32'(m_mode != 0));
        chk("R11", "bus_rdata", 32'(bus_rdata), 32'(exp_rdata()));
        chk("R10", "irq_pend",  32'(irq_pend),  32'(m_pend));
        chk("R10", "irq_take",  32'(irq_take),  32'(exp_take()));
    endtask

    // Next model state from the inputs applied in this cycle.
    task automatic model_update();
        logic cw, kio, kpg, held;
        cw   = bus_wr && bus_sel && !bus_is_dma;
        kio  = cw && (bus_wdata == 8'hD8);
        kpg  = cw && (bus_wdata == 8'h9D);
        held = (m_mode != 0);
        m_pend = (m_pend & ~(held ? '0 : irq_ack)) | irq_req;
        if (kio)      begin m_mode = 1; m_cnt = 0; end
        else if (kpg) begin m_mode = 2; m_cnt = 0; end
        else if (m_mode == 2 && (dmem_wr || sleep_exec)) m_mode = 0;
        else if (m_mode == 1 && prot_reg_wr)             m_mode = 0;
        else if (m_mode != 0 && instr_retire) begin
            if (m_cnt == 3) m_mode = 0;
            else            m_cnt  = m_cnt + 1;
        end
        if (m_mode == 0) m_cnt = 0;
    endtask

    task automatic step(input logic sel, input logic wr, input logic dma,
                        input logic [7:0] d, input logic ret, input logic dw,
                        input logic slp, input logic pw,
                        input logic [NI-1:0] rq, input logic [NI-1:0] ak);
        @(negedge clk);
        compare_all();
        bus_sel = sel; bus_wr = wr; bus_is_dma = dma; bus_wdata = d;
        instr_retire = ret; dmem_wr = dw; sleep_exec = slp; prot_reg_wr = pw;
        irq_req = rq; irq_ack = ak;
        model_update();
    endtask

    task automatic idle(input logic ret);
        step(0, 0, 0, 8'h00, ret, 0, 0, 0, '0, '0);
    endtask

    task automatic key(input logic [7:0] k, input logic dma);
        step(1, 1, dma, k, 0, 0, 0, 0, '0, '0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R12: reset state visible while reset is held.
        compare_all();
        @(negedge clk);
        rst_n = 1'b1;
        idle(0);

        // R1 / R3: I/O window, gaps without retire, four retires close it.
        cur_tag = "R1"; key(8'hD8, 0);
        cur_tag = "R3"; idle(1); idle(0); idle(1); idle(1); idle(0); idle(1); idle(1); idle(1);

        // R3: retire in the key-write cycle is not counted.
        step(1, 1, 0, 8'h9D, 1, 0, 0, 0, '0, '0);
        repeat (5) idle(1);

        // R2 / R7: program-memory window aborted by data write, then by sleep.
        cur_tag = "R2"; key(8'h9D, 0); idle(1);
        cur_tag = "R7"; step(0, 0, 0, 0, 0, 1, 0, 0, '0, '0); idle(0);
        key(8'h9D, 0); step(0, 0, 0, 0, 0, 0, 1, 0, '0, '0); idle(0);
        // R7: I/O window ignores data write and sleep.
        key(8'hD8, 0); step(0, 0, 0, 0, 0, 1, 1, 0, '0, '0); idle(0);

        // R8: protected write consumes the I/O window; no effect in program mode.
        cur_tag = "R8"; step(0, 0, 0, 0, 0, 0, 0, 1, '0, '0); idle(0);
        key(8'h9D, 0); step(0, 0, 0, 0, 0, 0, 0, 1, '0, '0); idle(0);
        repeat (4) idle(1);

        // R4: DMA keys rejected when idle and while open.
        cur_tag = "R4"; key(8'hD8, 1); key(8'h9D, 1); idle(0);
        key(8'hD8, 0); idle(1); idle(1); key(8'hD8, 1); idle(1); idle(1); idle(0);

        // R5: bad values and unselected writes do not disturb the window.
        cur_tag = "R5"; key(8'h5A, 0); key(8'hD8, 0); idle(1);
        key(8'h00, 0); step(0, 1, 0, 8'h9D, 0, 0, 0, 0, '0, '0); idle(1); idle(1); idle(1); idle(0);

        // R6: restart in the other mode resets the count.
        cur_tag = "R6"; key(8'hD8, 0); idle(1); idle(1); idle(1);
        step(1, 1, 0, 8'h9D, 1, 0, 0, 0, '0, '0);
        idle(1); idle(1); idle(1); idle(1); idle(0);

        // R9 / R10: request in window held, ack ignored, released afterwards.
        cur_tag = "R9"; key(8'h9D, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 4'b0101, 4'b0000);
        step(0, 0, 0, 0, 1, 0, 0, 0, 4'b0000, 4'b0101);
        idle(1); idle(1); idle(1); idle(0);
        cur_tag = "R10";
        step(0, 0, 0, 0, 0, 0, 0, 0, 4'b0100, 4'b0101);
        step(0, 0, 0, 0, 0, 0, 0, 0, 4'b0000, 4'b1111);
        idle(0);

        // Random traffic with keys, aborts and interrupts.
        cur_tag = "R5";
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] d;
            int unsigned pick;
            pick = $urandom % 4;
            d = (pick == 0) ? 8'hD8 : (pick == 1) ? 8'h9D : 8'($urandom);
            step(($urandom % 4) != 0, ($urandom % 5) == 0, ($urandom % 4) == 0, d,
                 ($urandom % 2) == 0, ($urandom % 10) == 0, ($urandom % 20) == 0,
                 ($urandom % 10) == 0,
                 (($urandom % 6) == 0) ? NI'($urandom) : '0, NI'($urandom));
        end
        @(negedge clk);
        compare_all();
        finish_run();
    end

endmodule